// File: doc/BRIEF.md
# Multiplexed GPIO Port Bank

This block controls a bank of general-purpose pins. Each pin has four bits of state: a data bit, a direction bit, a primary-function select and an extended-function select. From these bits the block decides, pin by pin, who owns the pad driver. The owner is the plain port, whose direction bit gates the data bit onto the pad. It can also be a primary peripheral, which supplies its own value and output enable, or an extended peripheral, which does the same. The extended select beats the primary select, and the primary select beats the port. A parameter mask marks some pins as shared. On a shared pin in primary mode, the direction bit chooses the role. Direction 0 makes the pin a peripheral input, for example a wait or bus-request strobe. Direction 1 makes it a peripheral output that always drives, for example a chip enable.

Software reaches the four registers through a word-wide command/response stream. A command is taken when `cmd_valid` and `cmd_ready` are both high. A read returns one response word, which is held stable until `rsp_ready` is high. `cmd_ready` stays low while a response is waiting and `rsp_ready` is low, so back-pressure on the response side stalls new commands. Writes produce no response.

There are two resets. A cold reset clears every register to its default. At that default, a small group of pins comes up in extended (debug output) mode. A warm reset leaves all pin state as it was. It only drops a pending response and blocks commands while it is held.

Top module: `gpio_mux_port`

## Requirements
- R1: After cold reset, the data, direction and primary-select registers read 0, and the extended-select register reads `XSEL_RST` (default 0x001F, pins 0 to 4). Those pins follow `ext_oe`/`ext_out` right away.
- R2: A pin with both selects at 0 has `pad_oe` equal to its direction bit. When the direction bit is 1, `pad_out` equals its data bit.
- R3: A read at offset 0x0 returns the data bit for pins with direction 1 and the live `pad_in` level for pins with direction 0.
- R4: A data write while a pin is an input updates the data register but leaves `pad_oe` low. Setting the direction bit to 1 afterwards drives the stored value.
- R5: A non-shared pin with primary select 1 and extended select 0 has `pad_oe = pri_oe` and `pad_out = pri_out`.
- R6: An extended select of 1 gives `pad_oe = ext_oe` and `pad_out = ext_out`, whatever the primary select and direction bits hold.
- R7: A shared pin (bit set in `SHARED_MASK`, default pins 12 and 13) in primary mode with direction 0 has `pad_oe = 0` and `pri_in_tap = pad_in`. With direction 1 it has `pad_oe = 1`, `pad_out = pri_out` and `pri_in_tap = 0`.
- R8: A non-shared pin in primary mode has `pri_in_tap = pad_in`. A pin not in primary mode has `pri_in_tap = 0`.
- R9: A warm reset keeps all four registers. It clears a pending response and holds `cmd_ready` low while asserted.
- R10: A read accepted at a clock edge raises `rsp_valid` after that edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` stays stable and `cmd_ready` is low.
- R11: The register offsets are 0x0 data, 0x4 direction, 0x8 primary select and 0xC extended select. A command with address bits [1:0] not equal to 0 writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, clears all state |
| warm_rst_n | input | 1 | Warm reset, active low, keeps pin state |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address of the register |
| cmd_wdata | input | NUM_PINS | Write data |
| rsp_valid | output | 1 | Read response waiting |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | NUM_PINS | Read response word |
| pri_out | input | NUM_PINS | Primary peripheral output values |
| pri_oe | input | NUM_PINS | Primary peripheral output enables |
| ext_out | input | NUM_PINS | Extended peripheral output values |
| ext_oe | input | NUM_PINS | Extended peripheral output enables |
| pri_in_tap | output | NUM_PINS | Pad level passed to the primary peripheral input |
| pad_in | input | NUM_PINS | Live pad levels |
| pad_out | output | NUM_PINS | Pad driver values |
| pad_oe | output | NUM_PINS | Pad driver enables |

## Verification
Warm-reset retention is the hardest case to reach. To see it, the bench first moves all four registers away from their cold defaults. It then leaves a read response unconsumed, pulses the warm reset, and reads every register back. Checking the shared-pin roles needs the same pin in primary mode with each direction value in turn. The vector table does this, placing a shared pin and a non-shared pin side by side under identical peripheral inputs.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PSEL = 2'd2,
    REG_XSEL = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    OWN_PORT = 2'd0,
    OWN_PRI  = 2'd1,
    OWN_EXT  = 2'd2
  } pin_owner_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter logic [NUM_PINS-1:0] XSEL_RST = '0
) (
  input  logic                clk,
  input  logic                cold_rst_n,
  input  logic                wr_en,
  input  reg_idx_e            idx,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] data_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] psel_q,
  output logic [NUM_PINS-1:0] xsel_q,
  output logic [NUM_PINS-1:0] rd_word
);
  // Only the cold reset touches the pin state.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      psel_q <= '0;
      xsel_q <= XSEL_RST;
    end else if (wr_en) begin
      unique case (idx)
        REG_DATA: data_q <= wdata;
        REG_DIR:  dir_q  <= wdata;
        REG_PSEL: psel_q <= wdata;
        REG_XSEL: xsel_q <= wdata;
        default:  ;
      endcase
    end
  end

  // Data read: stored bit for outputs, live pad for inputs.
  always_comb begin
    unique case (idx)
      REG_DATA: rd_word = (data_q & dir_q) | (pad_in & ~dir_q);
      REG_DIR:  rd_word = dir_q;
      REG_PSEL: rd_word = psel_q;
      REG_XSEL: rd_word = xsel_q;
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_mux_pkg::*;
#(
  parameter bit IS_SHARED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_i,
  input  logic dir_i,
  input  logic psel_i,
  input  logic xsel_i,
  input  logic pri_out_i,
  input  logic pri_oe_i,
  input  logic ext_out_i,
  input  logic ext_oe_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic tap_o
);
  pin_owner_e owner;

  always_comb begin
    if (xsel_i)      owner = OWN_EXT;
    else if (psel_i) owner = OWN_PRI;
    else             owner = OWN_PORT;
  end

  generate
    if (IS_SHARED) begin : g_shared
      // Direction picks the peripheral role on this pin.
      always_comb begin
        pad_out_o = data_i;
        pad_oe_o  = dir_i;
        tap_o     = 1'b0;
        unique case (owner)
          OWN_EXT: begin
            pad_out_o = ext_out_i;
            pad_oe_o  = ext_oe_i;
          end
          OWN_PRI: begin
            pad_out_o = pri_out_i;
            pad_oe_o  = dir_i;
            tap_o     = dir_i ? 1'b0 : pad_in_i;
          end
          default: ;
        endcase
      end

      AST_SHARED_IN_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_i && !xsel_i && !dir_i) |-> (!pad_oe_o && tap_o == pad_in_i)); // R7
      AST_SHARED_OUT_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_i && !xsel_i && dir_i) |-> (pad_oe_o && !tap_o)); // R7
    end else begin : g_plain
      always_comb begin
        pad_out_o = data_i;
        pad_oe_o  = dir_i;
        tap_o     = 1'b0;
        unique case (owner)
          OWN_EXT: begin
            pad_out_o = ext_out_i;
            pad_oe_o  = ext_oe_i;
          end
          OWN_PRI: begin
            pad_out_o = pri_out_i;
            pad_oe_o  = pri_oe_i;
            tap_o     = pad_in_i;
          end
          default: ;
        endcase
      end
    end
  endgenerate

  AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    xsel_i |-> (pad_oe_o == ext_oe_i && !tap_o)); // R6
  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xsel_i && !psel_i && !dir_i) |-> !pad_oe_o); // R2
endmodule

// File: rtl/gpio_rsp_slot.sv
module gpio_rsp_slot #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_PINS-1:0] XSEL_RST    = 16'h001F,
  parameter logic [NUM_PINS-1:0] SHARED_MASK = 16'h3000
) (
  input  logic                clk,
  input  logic                cold_rst_n,
  input  logic                warm_rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [NUM_PINS-1:0] cmd_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [NUM_PINS-1:0] rsp_rdata,
  input  logic [NUM_PINS-1:0] pri_out,
  input  logic [NUM_PINS-1:0] pri_oe,
  input  logic [NUM_PINS-1:0] ext_out,
  input  logic [NUM_PINS-1:0] ext_oe,
  output logic [NUM_PINS-1:0] pri_in_tap,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int IDX_W = ADDR_W - 2;

  logic                rst_any_n;
  logic                accept;
  logic                aligned;
  reg_idx_e            idx;
  logic [NUM_PINS-1:0] data_q, dir_q, psel_q, xsel_q, rd_word, rsp_word;

  assign rst_any_n = cold_rst_n & warm_rst_n;
  assign cmd_ready = rst_any_n & (~rsp_valid | rsp_ready);
  assign accept    = cmd_valid & cmd_ready;
  assign aligned   = (cmd_addr[1:0] == 2'b00);
  assign idx       = reg_idx_e'(cmd_addr[IDX_W+1:2]);
  assign rsp_word  = aligned ? rd_word : '0;

  gpio_regfile #(
    .NUM_PINS (NUM_PINS),
    .XSEL_RST (XSEL_RST)
  ) i_regs (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .wr_en      (accept & cmd_write & aligned),
    .idx        (idx),
    .wdata      (cmd_wdata),
    .pad_in     (pad_in),
    .data_q     (data_q),
    .dir_q      (dir_q),
    .psel_q     (psel_q),
    .xsel_q     (xsel_q),
    .rd_word    (rd_word)
  );

  gpio_rsp_slot #(.WIDTH(NUM_PINS)) i_rsp (
    .clk       (clk),
    .rst_n     (rst_any_n),
    .load      (accept & ~cmd_write),
    .load_data (rsp_word),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell #(.IS_SHARED(SHARED_MASK[p])) i_cell (
      .clk       (clk),
      .rst_n     (rst_any_n),
      .data_i    (data_q[p]),
      .dir_i     (dir_q[p]),
      .psel_i    (psel_q[p]),
      .xsel_i    (xsel_q[p]),
      .pri_out_i (pri_out[p]),
      .pri_oe_i  (pri_oe[p]),
      .ext_out_i (ext_out[p]),
      .ext_oe_i  (ext_oe[p]),
      .pad_in_i  (pad_in[p]),
      .pad_out_o (pad_out[p]),
      .pad_oe_o  (pad_oe[p]),
      .tap_o     (pri_in_tap[p])
    );
  end

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_any_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> rsp_valid); // R10
  AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_any_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R10
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> ($stable(data_q) && $stable(dir_q) && $stable(psel_q) && $stable(xsel_q))); // R9
  AST_WARM_NO_RSP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |-> (!rsp_valid && !cmd_ready)); // R9
endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  typedef struct packed {
    logic [N-1:0] dat, dir, ps, xs, po, poe, xo, xoe, pin, e_oe, e_out, e_tap;
  } vec_t;

  // e_out is compared only where e_oe is 1
  localparam vec_t VECS [6] = '{
    '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hA5C3, 16'h0000},
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h3333, 16'h0F0F, 16'h0000, 16'h0000, 16'h5A5A, 16'h0F0F, 16'h0303, 16'h5A5A},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hF000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h3000, 16'h3000, 16'hCFFF},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h00FF, 16'h5555, 16'hFF00, 16'hAAAA, 16'h00F0, 16'hFFFF, 16'hFFF0, 16'h55A0, 16'hCF00},
    '{16'h00F0, 16'h0FF0, 16'hF000, 16'h0F00, 16'h0000, 16'h0000, 16'hFFFF, 16'h0300, 16'hA55A, 16'h03F0, 16'h03F0, 16'hA000}
  };

  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0] cmd_addr = '0;
  logic [N-1:0] cmd_wdata = '0;
  logic [N-1:0] pri_out = '0, pri_oe = '0, ext_out = '0, ext_oe = '0, pad_in = '0;
  logic cmd_ready, rsp_valid;
  logic [N-1:0] rsp_rdata, pri_in_tap, pad_out, pad_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [N-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port i_gpio_mux_port (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pri_out(pri_out), .pri_oe(pri_oe), .ext_out(ext_out), .ext_oe(ext_oe),
    .pri_in_tap(pri_in_tap), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic cold_reset();
    @(negedge clk); cold_rst_n = 1'b0;
    repeat (2) @(negedge clk); cold_rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    pad_in = 16'hBEEF;

    // R1: cold defaults
    bus_read(4'h4, rd); check("R1 dir reset", rd, 16'h0000);
    bus_read(4'h8, rd); check("R1 psel reset", rd, 16'h0000);
    bus_read(4'hC, rd); check("R1 xsel reset", rd, 16'h001F);
    check("R3 data read in input mode", 16'h0000, 16'h0000);
    bus_read(4'h0, rd); check("R3 reset data read shows pads", rd, 16'hBEEF);
    check("R1 pad_oe idle", pad_oe, 16'h0000);
    ext_oe = 16'hFFFF; ext_out = 16'h0015;
    @(negedge clk);
    check("R1 debug pins oe", pad_oe, 16'h001F);
    check("R1 debug pins out", pad_out & 16'h001F, 16'h0015);
    ext_oe = '0; ext_out = '0;
    bus_write(4'hC, 16'h0000);

    // R4: input-mode write isolation
    bus_write(4'h0, 16'h1234);
    @(negedge clk);
    check("R4 no drive after input-mode write", pad_oe, 16'h0000);
    bus_write(4'h4, 16'hFFFF);
    @(negedge clk);
    check("R4 oe after direction set", pad_oe, 16'hFFFF);
    check("R4 stored value driven", pad_out, 16'h1234);

    // R3: mixed read
    bus_write(4'h0, 16'h0F0F);
    bus_write(4'h4, 16'h00FF);
    pad_in = 16'hF0F0;
    bus_read(4'h0, rd); check("R3 mixed data read", rd, 16'hF00F);

    // R11: misaligned ignored
    bus_write(4'h5, 16'hAAAA);
    bus_read(4'h4, rd); check("R11 misaligned write ignored", rd, 16'h00FF);
    bus_read(4'h6, rd); check("R11 misaligned read zero", rd, 16'h0000);

    // Vector table: R2 R5 R6 R7 R8
    foreach (VECS[k]) begin
      bus_write(4'h0, VECS[k].dat);
      bus_write(4'h4, VECS[k].dir);
      bus_write(4'h8, VECS[k].ps);
      bus_write(4'hC, VECS[k].xs);
      pri_out = VECS[k].po; pri_oe = VECS[k].poe;
      ext_out = VECS[k].xo; ext_oe = VECS[k].xoe;
      pad_in = VECS[k].pin;
      @(negedge clk);
      check($sformatf("R2/R5/R6/R7 vector %0d pad_oe", k), pad_oe, VECS[k].e_oe);
      check($sformatf("R2/R5/R6/R7 vector %0d pad_out", k), pad_out & VECS[k].e_oe, VECS[k].e_out);
      check($sformatf("R7/R8 vector %0d tap", k), pri_in_tap, VECS[k].e_tap);
    end

    // R10: back-pressure on response
    rsp_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 4'h8;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 rsp_valid after read", {15'd0, rsp_valid}, 16'd1);
    repeat (3) @(negedge clk);
    check("R10 rsp held", rsp_rdata, 16'hF000);
    check("R10 cmd stalled", {15'd0, cmd_ready}, 16'd0);

    // R9: warm reset drops the response, keeps registers
    warm_rst_n = 1'b0;
    @(negedge clk);
    check("R9 response dropped", {15'd0, rsp_valid}, 16'd0);
    check("R9 commands blocked", {15'd0, cmd_ready}, 16'd0);
    @(negedge clk);
    warm_rst_n = 1'b1;
    rsp_ready = 1'b1;
    pad_in = 16'h0000;
    bus_read(4'h0, rd); check("R9 data kept", rd, 16'h00F0);
    bus_read(4'h4, rd); check("R9 dir kept", rd, 16'h0FF0);
    bus_read(4'h8, rd); check("R9 psel kept", rd, 16'hF000);
    bus_read(4'hC, rd); check("R9 xsel kept", rd, 16'h0F00);

    // R1: cold reset restores defaults
    cold_reset();
    bus_read(4'h4, rd); check("R1 dir after cold", rd, 16'h0000);
    bus_read(4'h8, rd); check("R1 psel after cold", rd, 16'h0000);
    bus_read(4'hC, rd); check("R1 xsel after cold", rd, 16'h001F);
    bus_write(4'h4, 16'hFFFF);
    bus_read(4'h0, rd); check("R1 data after cold", rd, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule